// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Overrides

This block is one general-purpose I/O port of a microcontroller, with a parameterised number of pins (eight by default). Each pin has a direction bit and a port bit. The port bit drives the pad as the output value when the pin is an output, and it requests a pull-up when the pin is an input. The pad input reaches a pin-read path through a two-stage synchronizer: a latch that is transparent while the clock is low, followed by a rising-edge flop. The synchronized value is also handed to the peripherals.

Any on-chip peripheral can take over a pin through a set of per-pin controls. There is one enable/value pair each for pull-up, direction, output value and digital-input enable. There is also a toggle request that flips the stored port bit. A global pull-up disable and a sleep signal are shared by all ports. Software reaches the registers through write and read strobes that all pins of the port share. These strobes act on a common write-data bus and a registered read-data bus.

Top module: `gpio_ovr_port`

## Requirements
- R1: A synchronous active-high reset clears the direction bits, the port bits, the synchronizer flop and the read data to 0.
- R2: `wr_dir` and `wr_port` load `wdata` into the direction or port bits at the clock edge. After the edge that samples a read strobe, `rdata` holds the selected value. When several read strobes are high, the priority is direction, then port, then pin. `rdata` is 0 after an edge with no read strobe.
- R3: A pin-register write (`wr_tgl`) flips every port bit whose `wdata` bit is 1 and leaves bits with 0 unchanged. If `wr_port` is high in the same cycle, the flip applies to the newly written value.
- R4: Each cycle that `tgl_ovr_en[i]` is high flips port bit i once. If a pin-register write also flips that bit in the same cycle, the bit still flips only once.
- R5: `pad_oe[i]` is `dir_ovr_val[i]` when `dir_ovr_en[i]` is 1, and the direction bit otherwise. `pad_out[i]` is `out_ovr_val[i]` when `out_ovr_en[i]` is 1, and the port bit otherwise.
- R6: `pad_pu[i]` is `pu_ovr_val[i]` when `pu_ovr_en[i]` is 1. Otherwise it is 1 only when the direction bit is 0, the port bit is 1 and `pu_disable` is 0.
- R7: The digital input of pin i is enabled by `din_ovr_val[i]` when `din_ovr_en[i]` is 1, and by `!sleep` otherwise. A disabled input feeds a constant 0 into the synchronizer.
- R8: A gated pad value present during the low phase before edge k is in the synchronizer after edge k. A pin read strobed in the cycle after edge k returns it after edge k+1. A pin read strobed in the cycle before edge k still returns the older value.
- R9: `periph_din` is the synchronizer output. It updates at the same edge at which the pin read path sees a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | synchronous active-high reset |
| wdata | input | N | register write data |
| wr_dir | input | 1 | write strobe, direction bits |
| wr_port | input | 1 | write strobe, port bits |
| wr_tgl | input | 1 | write strobe, pin register (toggle mask) |
| rd_dir | input | 1 | read strobe, direction bits |
| rd_port | input | 1 | read strobe, port bits |
| rd_pin | input | 1 | read strobe, synchronized pin values |
| rdata | output | N | registered read data |
| pu_disable | input | 1 | global pull-up disable |
| sleep | input | 1 | sleep gate for digital inputs |
| pu_ovr_en | input | N | pull-up override enable |
| pu_ovr_val | input | N | pull-up override value |
| dir_ovr_en | input | N | direction override enable |
| dir_ovr_val | input | N | direction override value |
| out_ovr_en | input | N | output value override enable |
| out_ovr_val | input | N | output value override value |
| tgl_ovr_en | input | N | port bit toggle request |
| din_ovr_en | input | N | input-enable override enable |
| din_ovr_val | input | N | input-enable override value |
| pad_in | input | N | pad input level |
| pad_out | output | N | pad output value |
| pad_oe | output | N | pad output enable |
| pad_pu | output | N | pad pull-up enable |
| periph_din | output | N | synchronized input tap for peripherals |

## Verification
The pad controls are combinational from the stored bits and the override inputs, so the bench checks them 1 ns after it drives a new input set, within the same cycle. Register writes and read strobes take effect at the next rising edge. The bench therefore checks `rdata` at the following falling edge against a value it computed from its model before that edge. The synchronizer output is due one edge after the gated pad value, and a pin read of it one edge later. The bench model advances its copy of the synchronizer at each edge and compares `periph_din` at every falling edge, so the two-edge pin-read latency is checked on every random read. A directed pair of back-to-back pin reads pins down that latency.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PORT = 2'd2,
    SEL_PIN  = 2'd3
  } rd_sel_e;

  // Read source select: direction has priority, then port, then pin.
  function automatic rd_sel_e pick_read(input logic rdir, input logic rport,
                                        input logic rpin);
    if (rdir)       return SEL_DIR;
    else if (rport) return SEL_PORT;
    else if (rpin)  return SEL_PIN;
    else            return SEL_NONE;
  endfunction
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] wdata,
  input  logic         wr_dir,
  input  logic         wr_port,
  input  logic         wr_tgl,
  input  logic [N-1:0] tgl_force,
  input  logic         rd_dir,
  input  logic         rd_port,
  input  logic         rd_pin,
  input  logic [N-1:0] pin_sync,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] port_q,
  output logic [N-1:0] rdata
);
  logic [N-1:0] port_base;
  logic [N-1:0] flip_mask;
  rd_sel_e      sel;

  always_comb begin
    port_base = wr_port ? wdata : port_q;
    flip_mask = (wr_tgl ? wdata : '0) | tgl_force;
    sel       = pick_read(rd_dir, rd_port, rd_pin);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      port_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      port_q <= port_base ^ flip_mask;
      case (sel)
        SEL_DIR:  rdata <= dir_q;
        SEL_PORT: rdata <= port_q;
        SEL_PIN:  rdata <= pin_sync;
        default:  rdata <= '0;
      endcase
    end
  end

  // R1: registers come out of reset cleared
  p_rst_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (dir_q == '0 && port_q == '0 && rdata == '0));

  // R2: direction write lands one edge later
  p_wr_dir_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_dir) && !$past(rst)) |-> dir_q == $past(wdata));

  // R2: no read strobe gives zero read data
  p_rd_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_dir) && !$past(rd_port) && !$past(rd_pin))
    |-> rdata == '0);

  // R4: without software writes the port bits change only where toggled
  p_tgl_only_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_port) && !$past(wr_tgl))
    |-> port_q == ($past(port_q) ^ $past(tgl_force)));
endmodule

// File: rtl/gpio_ovr_padmux.sv
module gpio_ovr_padmux #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] dir_q,
  input  logic [N-1:0] port_q,
  input  logic         pu_disable,
  input  logic         sleep,
  input  logic [N-1:0] pu_ovr_en,
  input  logic [N-1:0] pu_ovr_val,
  input  logic [N-1:0] dir_ovr_en,
  input  logic [N-1:0] dir_ovr_val,
  input  logic [N-1:0] out_ovr_en,
  input  logic [N-1:0] out_ovr_val,
  input  logic [N-1:0] din_ovr_en,
  input  logic [N-1:0] din_ovr_val,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_pu,
  output logic [N-1:0] din_en
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic pu_native;
    always_comb begin
      pu_native  = !dir_q[i] && port_q[i] && !pu_disable;
      pad_pu[i]  = pu_ovr_en[i]  ? pu_ovr_val[i]  : pu_native;
      pad_oe[i]  = dir_ovr_en[i] ? dir_ovr_val[i] : dir_q[i];
      pad_out[i] = out_ovr_en[i] ? out_ovr_val[i] : port_q[i];
      din_en[i]  = din_ovr_en[i] ? din_ovr_val[i] : !sleep;
    end

    // R6: native pull-up never on while the pin drives
    p_pu_oe_excl_r6: assert property (@(posedge clk) disable iff (rst)
      (!pu_ovr_en[i] && !dir_ovr_en[i]) |-> !(pad_pu[i] && pad_oe[i]));

    // R6: global disable wins over the port bit
    p_pud_r6: assert property (@(posedge clk) disable iff (rst)
      (pu_disable && !pu_ovr_en[i]) |-> !pad_pu[i]);
  end
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pad_in,
  input  logic [N-1:0] din_en,
  output logic [N-1:0] sync_q
);
  logic [N-1:0] gated;
  logic [N-1:0] lat_q;

  assign gated = pad_in & din_en;

  // Latch stage: open while the clock is low, closed while it is high.
  always_latch begin
    if (!clk) lat_q <= gated;
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= lat_q;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R7: a disabled input yields a zero in the synchronizer
    p_gate_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(din_en[i])) |-> !sync_q[i]);
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] wdata,
  input  logic         wr_dir,
  input  logic         wr_port,
  input  logic         wr_tgl,
  input  logic         rd_dir,
  input  logic         rd_port,
  input  logic         rd_pin,
  output logic [N-1:0] rdata,
  input  logic         pu_disable,
  input  logic         sleep,
  input  logic [N-1:0] pu_ovr_en,
  input  logic [N-1:0] pu_ovr_val,
  input  logic [N-1:0] dir_ovr_en,
  input  logic [N-1:0] dir_ovr_val,
  input  logic [N-1:0] out_ovr_en,
  input  logic [N-1:0] out_ovr_val,
  input  logic [N-1:0] tgl_ovr_en,
  input  logic [N-1:0] din_ovr_en,
  input  logic [N-1:0] din_ovr_val,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_pu,
  output logic [N-1:0] periph_din
);
  logic [N-1:0] dir_q;
  logic [N-1:0] port_q;
  logic [N-1:0] din_en;
  logic [N-1:0] sync_q;

  gpio_ovr_regs #(.N(N)) u_regs (
    .clk(clk), .rst(rst), .wdata(wdata),
    .wr_dir(wr_dir), .wr_port(wr_port), .wr_tgl(wr_tgl),
    .tgl_force(tgl_ovr_en),
    .rd_dir(rd_dir), .rd_port(rd_port), .rd_pin(rd_pin),
    .pin_sync(sync_q), .dir_q(dir_q), .port_q(port_q), .rdata(rdata)
  );

  gpio_ovr_padmux #(.N(N)) u_mux (
    .clk(clk), .rst(rst), .dir_q(dir_q), .port_q(port_q),
    .pu_disable(pu_disable), .sleep(sleep),
    .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val),
    .dir_ovr_en(dir_ovr_en), .dir_ovr_val(dir_ovr_val),
    .out_ovr_en(out_ovr_en), .out_ovr_val(out_ovr_val),
    .din_ovr_en(din_ovr_en), .din_ovr_val(din_ovr_val),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .din_en(din_en)
  );

  gpio_ovr_sync #(.N(N)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .din_en(din_en), .sync_q(sync_q)
  );

  // R9: peripherals see the same synchronized tap as the pin read path
  assign periph_din = sync_q;
endmodule

// File: tb/gpio_ovr_port_test.sv
module gpio_ovr_port_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] wdata = '0;
  logic wr_dir = 0, wr_port = 0, wr_tgl = 0;
  logic rd_dir = 0, rd_port = 0, rd_pin = 0;
  logic pu_disable = 0, sleep = 0;
  logic [N-1:0] pu_ovr_en = '0, pu_ovr_val = '0, dir_ovr_en = '0, dir_ovr_val = '0;
  logic [N-1:0] out_ovr_en = '0, out_ovr_val = '0, tgl_ovr_en = '0;
  logic [N-1:0] din_ovr_en = '0, din_ovr_val = '0, pad_in = '0;
  logic [N-1:0] rdata, pad_out, pad_oe, pad_pu, periph_din;

  always #4 clk = ~clk;

  gpio_ovr_port #(.N(N)) uut (
    .clk(clk), .rst(rst), .wdata(wdata),
    .wr_dir(wr_dir), .wr_port(wr_port), .wr_tgl(wr_tgl),
    .rd_dir(rd_dir), .rd_port(rd_port), .rd_pin(rd_pin), .rdata(rdata),
    .pu_disable(pu_disable), .sleep(sleep),
    .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val),
    .dir_ovr_en(dir_ovr_en), .dir_ovr_val(dir_ovr_val),
    .out_ovr_en(out_ovr_en), .out_ovr_val(out_ovr_val),
    .tgl_ovr_en(tgl_ovr_en), .din_ovr_en(din_ovr_en), .din_ovr_val(din_ovr_val),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .periph_din(periph_din)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [N-1:0] dir_m = '0, port_m = '0, sync_m = '0, exp_rd = '0;
  string rd_tag = "R1";
  string tag = "";
  bit prev_gate = 0;
  bit primed = 0;

  task automatic chk(input string t, input string what,
                     input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", t, what, got, exp);
    end
  endtask

  function automatic logic [N-1:0] mux(input logic [N-1:0] en,
                                       input logic [N-1:0] v,
                                       input logic [N-1:0] base);
    return (en & v) | (~en & base);
  endfunction

  function automatic logic [N-1:0] din_en_f();
    return mux(din_ovr_en, din_ovr_val, {N{~sleep}});
  endfunction

  // Called with inputs already driven just after a falling edge.
  task automatic step();
    logic [N-1:0] pu_nat;
    logic [N-1:0] en;
    #1;
    if (!rst) begin
      pu_nat = ~dir_m & port_m & {N{~pu_disable}};
      chk("R5", "pad_oe", pad_oe, mux(dir_ovr_en, dir_ovr_val, dir_m));
      chk("R5", "pad_out", pad_out, mux(out_ovr_en, out_ovr_val, port_m));
      chk("R6", "pad_pu", pad_pu, mux(pu_ovr_en, pu_ovr_val, pu_nat));
    end
    en = din_en_f();
    prev_gate = (en != {N{1'b1}});
    if (tag != "") rd_tag = tag;
    else if (rd_dir || rd_port) rd_tag = "R2";
    else if (rd_pin) rd_tag = "R8";
    else rd_tag = "R2";
    if (rst) begin
      exp_rd = '0; dir_m = '0; port_m = '0; sync_m = '0;
    end else begin
      if (rd_dir) exp_rd = dir_m;
      else if (rd_port) exp_rd = port_m;
      else if (rd_pin) exp_rd = sync_m;
      else exp_rd = '0;
      port_m = (wr_port ? wdata : port_m) ^ ((wr_tgl ? wdata : '0) | tgl_ovr_en);
      if (wr_dir) dir_m = wdata;
      sync_m = pad_in & en;
    end
    @(negedge clk);
    chk(rd_tag, "rdata", rdata, exp_rd);
    chk(prev_gate ? "R7" : "R9", "periph_din", periph_din, sync_m);
    primed = 1;
  endtask

  task automatic idle();
    wr_dir = 0; wr_port = 0; wr_tgl = 0;
    rd_dir = 0; rd_port = 0; rd_pin = 0;
    tgl_ovr_en = '0; tag = "";
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk);
    rst = 1;
    step(); step();
    rst = 0;
    // R1: reset state visible at the ports
    idle(); tag = "R1"; rd_dir = 1; step();
    chk("R1", "pad_oe after reset", pad_oe, '0);
    idle(); tag = "R1"; rd_port = 1; step();

    // R3: pin-register write toggles only ones
    idle(); wr_port = 1; wdata = 8'h0F; step();
    idle(); wr_tgl = 1; wdata = 8'h3C; step();
    idle(); tag = "R3"; rd_port = 1; step();
    chk("R3", "port after toggle", exp_rd, 8'h33);
    idle(); wr_port = 1; wr_tgl = 1; wdata = 8'h81; step();
    idle(); tag = "R3"; rd_port = 1; step();
    chk("R3", "write plus toggle", exp_rd, 8'h00);

    // R4: toggle requests from a peripheral
    idle(); tgl_ovr_en = 8'h81; step(); step();
    idle(); tgl_ovr_en = 8'h18; wr_tgl = 1; wdata = 8'h18; step();
    idle(); tag = "R4"; rd_port = 1; step();
    chk("R4", "port after override toggles", exp_rd, 8'h18);

    // R2: read priority with all strobes
    idle(); wr_dir = 1; wdata = 8'hC3; step();
    idle(); tag = "R2"; rd_dir = 1; rd_port = 1; rd_pin = 1; step();

    // R8: latency of pin reads
    idle(); pad_in = 8'h00; step(); step();
    idle(); pad_in = 8'hA5; tag = "R8"; rd_pin = 1; step();
    chk("R8", "pin read before sync edge", exp_rd, 8'h00);
    idle(); tag = "R8"; rd_pin = 1; step();
    chk("R8", "pin read after sync edge", exp_rd, 8'hA5);

    // R7: sleep gate and its override
    idle(); sleep = 1; pad_in = 8'hFF; step();
    idle(); tag = "R7"; rd_pin = 1; step();
    chk("R7", "pin read while asleep", exp_rd, 8'h00);
    idle(); din_ovr_en = 8'h0F; din_ovr_val = 8'h05; step();
    idle(); tag = "R7"; rd_pin = 1; step();
    chk("R7", "pin read with input override", exp_rd, 8'h05);
    sleep = 0; din_ovr_en = '0;

    // R6: pull-up with global disable
    idle(); wr_dir = 1; wdata = 8'h00; step();
    idle(); wr_port = 1; wdata = 8'hF0; pu_disable = 1; step();
    pu_disable = 0; step();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      wdata   = N'($urandom);
      wr_dir  = ($urandom % 5) == 0;
      wr_port = ($urandom % 5) == 0;
      wr_tgl  = ($urandom % 5) == 0;
      rd_dir  = ($urandom % 4) == 0;
      rd_port = ($urandom % 4) == 0;
      rd_pin  = ($urandom % 3) == 0;
      pu_disable = ($urandom % 6) == 0;
      sleep      = ($urandom % 6) == 0;
      pu_ovr_en  = N'($urandom & $urandom);  pu_ovr_val  = N'($urandom);
      dir_ovr_en = N'($urandom & $urandom);  dir_ovr_val = N'($urandom);
      out_ovr_en = N'($urandom & $urandom);  out_ovr_val = N'($urandom);
      tgl_ovr_en = N'($urandom & $urandom & $urandom);
      din_ovr_en = N'($urandom & $urandom);  din_ovr_val = N'($urandom);
      pad_in     = N'($urandom);
      if (($urandom % 50) == 0) rst = 1; else rst = 0;
      step();
    end
    rst = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule